// File: doc/BRIEF.md
# Implication-Logic XOR Step Sequencer

This block is a cycle-level model of a four-cell stateful-logic register file that computes an exclusive OR using only two destructive primitives. A clear primitive forces one cell to 0. An implication primitive takes a source cell p and a target cell q and overwrites q with (not p) or q, leaving p as it was. A fixed nine-step micro-program works on two operand cells (A, B) and two scratch cells (S0, S1). It runs one primitive per clock cycle and leaves A XOR B in scratch cell S0.

A caller presents the two operand bits and pulses `start` while the block is idle. The operands are written into cells A and B, and both scratch cells are cleared. The block then reports `busy` for nine cycles and exposes the index of the step about to run. It pulses `done` once the ninth step has written its cell. Because the program works in place, operand cell B is destroyed along the way and ends holding (not A) or B. All four cells are visible on the outputs at every cycle, which makes every intermediate value observable.

Top module: `imp_xor_seq`

## Requirements
- R1: After synchronous reset, all four cells read 0, `busy` and `done` are 0 and `step_idx` is 0.
- R2: A `start` seen while idle loads `a_in` into cell A and `b_in` into cell B and clears S0 and S1 at that edge. On the following cycle `busy` is 1 and `step_idx` is 0.
- R3: While busy, exactly one step runs per clock edge. `step_idx` counts 0 to 8 and gives the step that the next edge executes. Steps 0..8 are, in this order: clear S0; A imp S0; clear S1; B imp S1; A imp B; S0 imp S1; clear S0; S1 imp S0; B imp S0.
- R4: A clear step leaves its target cell at 0 whatever it held.
- R5: An implication step sets its target to (not source) or target, and every other cell, the source included, keeps its value.
- R6: The edge that runs step 8 drops `busy` and raises `done`. `done` stays high for exactly one cycle, and `step_idx` returns to 0.
- R7: When `done` is high, S0 holds A XOR B for the loaded operands, and cell A still holds the loaded A.
- R8: When `done` is high, cell B holds (not A) or B instead of the loaded B.
- R9: A `start` pulse while busy is ignored. The running program, its cell values and its timing are unchanged.
- R10: While idle with no `start`, all cells hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load operands and run the program |
| a_in | input | 1 | Operand for cell A, sampled with an accepted start |
| b_in | input | 1 | Operand for cell B, sampled with an accepted start |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse after the last step |
| step_idx | output | 4 | Index of the step executed at the next edge |
| cell_a | output | 1 | Cell A contents |
| cell_b | output | 1 | Cell B contents |
| cell_s0 | output | 1 | Scratch cell S0 (holds the result at the end) |
| cell_s1 | output | 1 | Scratch cell S1 |

## Verification
The assertions assume that the operand inputs matter only at the edge where an idle block accepts `start`, and that `start` may arrive at any time, busy included. They also assume that reset is applied synchronously before the first request. The stimulus drives every input half a cycle away from the active edge. It holds each request for a single cycle and raises `start`, with inverted operands, in the middle of one run. That run exercises the ignore rule, and the other runs stay inside the program's normal sequence.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    localparam int NUM_CELLS = 4;
    localparam int NUM_STEPS = 9;
    localparam int IDX_W     = $clog2(NUM_STEPS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    typedef enum logic [1:0] {
        CELL_A  = 2'd0,
        CELL_B  = 2'd1,
        CELL_S0 = 2'd2,
        CELL_S1 = 2'd3
    } cell_id_e;

    typedef enum logic {
        OP_CLR = 1'b0,
        OP_IMP = 1'b1
    } prim_op_e;

    typedef struct packed {
        prim_op_e op;
        cell_id_e src;
        cell_id_e dst;
    } prim_t;

    typedef logic [NUM_CELLS-1:0] cell_vec_t;

    // Micro-program: S0 <- ~A, S1 <- ~B, B <- A imp B,
    // S1 <- ~A imp ~B, S0 <- ~S1, S0 <- B imp S0.
    function automatic prim_t program_step(input logic [IDX_W-1:0] idx);
        prim_t p;
        case (idx)
            IDX_W'(0): p = '{op: OP_CLR, src: CELL_S0, dst: CELL_S0};
            IDX_W'(1): p = '{op: OP_IMP, src: CELL_A,  dst: CELL_S0};
            IDX_W'(2): p = '{op: OP_CLR, src: CELL_S1, dst: CELL_S1};
            IDX_W'(3): p = '{op: OP_IMP, src: CELL_B,  dst: CELL_S1};
            IDX_W'(4): p = '{op: OP_IMP, src: CELL_A,  dst: CELL_B};
            IDX_W'(5): p = '{op: OP_IMP, src: CELL_S0, dst: CELL_S1};
            IDX_W'(6): p = '{op: OP_CLR, src: CELL_S0, dst: CELL_S0};
            IDX_W'(7): p = '{op: OP_IMP, src: CELL_S1, dst: CELL_S0};
            IDX_W'(8): p = '{op: OP_IMP, src: CELL_B,  dst: CELL_S0};
            default:   p = '{op: OP_IMP, src: CELL_A,  dst: CELL_A};
        endcase
        return p;
    endfunction

    function automatic cell_vec_t apply_prim(input cell_vec_t c, input prim_t p);
        cell_vec_t n;
        n = c;
        if (p.op == OP_CLR) begin
            n[p.dst] = 1'b0;
        end else begin
            n[p.dst] = ~c[p.src] | c[p.dst];
        end
        return n;
    endfunction

endpackage

// File: rtl/ixs_ctrl.sv
module ixs_ctrl
    import ixs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             exec,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);

    assign load = start && !busy;
    assign exec = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    idx  <= '0;
                end
            end else if (idx == LAST_IDX) begin
                busy <= 1'b0;
                done <= 1'b1;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && idx == '0)); // R2
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST_IDX) |=> (busy && idx == $past(idx) + 1'b1)); // R3
    AST_FINISH: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST_IDX) |=> (done && !busy && idx == '0)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1)); // R9

endmodule

// File: rtl/ixs_cells.sv
module ixs_cells
    import ixs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      a_val,
    input  logic      b_val,
    input  logic      exec,
    input  prim_t     prim,
    output cell_vec_t cells
);

    cell_vec_t cells_nxt;

    always_comb begin
        cells_nxt = cells;
        if (load) begin
            cells_nxt[CELL_A]  = a_val;
            cells_nxt[CELL_B]  = b_val;
            cells_nxt[CELL_S0] = 1'b0;
            cells_nxt[CELL_S1] = 1'b0;
        end else if (exec) begin
            cells_nxt = apply_prim(cells, prim);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else begin
            cells <= cells_nxt;
        end
    end

    AST_LOAD_CELLS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cells[CELL_A] == $past(a_val) && cells[CELL_B] == $past(b_val)
                  && !cells[CELL_S0] && !cells[CELL_S1])); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !exec) |=> $stable(cells)); // R10

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell_chk
        AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
            (exec && prim.op == OP_CLR && int'(prim.dst) == i) |=> !cells[i]); // R4
        AST_IMP_SET: assert property (@(posedge clk) disable iff (rst)
            (exec && prim.op == OP_IMP && int'(prim.dst) == i
             && (!cells[prim.src] || cells[i])) |=> cells[i]); // R5
        AST_IMP_KEEP: assert property (@(posedge clk) disable iff (rst)
            (exec && prim.op == OP_IMP && int'(prim.dst) == i
             && cells[prim.src] && !cells[i]) |=> !cells[i]); // R5
        AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (rst)
            (exec && int'(prim.dst) != i) |=> (cells[i] == $past(cells[i]))); // R5
    end

endmodule

// File: rtl/imp_xor_seq.sv
module imp_xor_seq
    import ixs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             a_in,
    input  logic             b_in,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] step_idx,
    output logic             cell_a,
    output logic             cell_b,
    output logic             cell_s0,
    output logic             cell_s1
);

    logic      load;
    logic      exec;
    prim_t     prim;
    cell_vec_t cells;

    ixs_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .exec  (exec),
        .busy  (busy),
        .done  (done),
        .idx   (step_idx)
    );

    assign prim = program_step(step_idx);

    ixs_cells u_cells (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .a_val (a_in),
        .b_val (b_in),
        .exec  (exec),
        .prim  (prim),
        .cells (cells)
    );

    assign cell_a  = cells[CELL_A];
    assign cell_b  = cells[CELL_B];
    assign cell_s0 = cells[CELL_S0];
    assign cell_s1 = cells[CELL_S1];

endmodule

// File: tb/imp_xor_seq_bench.sv
module imp_xor_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       a_in = 1'b0;
    logic       b_in = 1'b0;
    logic       busy, done;
    logic [3:0] step_idx;
    logic       cell_a, cell_b, cell_s0, cell_s1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    imp_xor_seq u_imp_xor_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .a_in     (a_in),
        .b_in     (b_in),
        .busy     (busy),
        .done     (done),
        .step_idx (step_idx),
        .cell_a   (cell_a),
        .cell_b   (cell_b),
        .cell_s0  (cell_s0),
        .cell_s1  (cell_s1)
    );

    // {a, b, expected xor, expected final B}
    localparam logic [3:0] VEC [4] = '{
        4'b0_0_0_1,
        4'b0_1_1_1,
        4'b1_0_1_0,
        4'b1_1_0_1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected cells {s1,s0,b,a} after k steps, from the step list of R3.
    function automatic logic [3:0] model(input logic a, input logic b, input int k);
        logic ca, cb, s0, s1;
        ca = a; cb = b; s0 = 1'b0; s1 = 1'b0;
        if (k >= 2) s0 = ~a;
        if (k >= 4) s1 = ~b;
        if (k >= 5) cb = ~a | b;
        if (k >= 6) s1 = a | ~b;
        if (k >= 7) s0 = 1'b0;
        if (k >= 8) s0 = ~a & b;
        if (k >= 9) s0 = a ^ b;
        return {s1, s0, cb, ca};
    endfunction

    task automatic run(input logic a, input logic b, input logic xr, input logic bf,
                       input bit poke);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 cells after load", {cell_s1, cell_s0, cell_b, cell_a}, model(a, b, 0));
        check("R2 busy/idx after load", {busy, step_idx}, {1'b1, 4'd0});
        for (int k = 1; k <= 9; k++) begin
            if (poke && k == 4) begin
                a_in = ~a; b_in = ~b; start = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            check(poke ? "R9 cells under ignored start" : "R3 R4 R5 cells after step",
                  {cell_s1, cell_s0, cell_b, cell_a}, model(a, b, k));
            if (k < 9)
                check("R3 busy/idx", {busy, done, step_idx}, {1'b1, 1'b0, 4'(k)});
        end
        check("R6 done/busy/idx at end", {busy, done, step_idx}, {1'b0, 1'b1, 4'd0});
        check("R7 xor in S0", cell_s0, xr);
        check("R7 A unchanged", cell_a, a);
        check("R8 B destroyed", cell_b, bf);
        @(negedge clk);
        check("R6 done one cycle", done, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 idle hold", {busy, cell_s1, cell_s0, cell_b, cell_a},
              {1'b0, model(a, b, 9)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {busy, done, step_idx, cell_s1, cell_s0, cell_b, cell_a}, 10'd0);

        for (int v = 0; v < 4; v++)
            run(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);

        // R9: start during a run with inverted operands
        run(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

        // R10: operand changes without start while idle have no effect
        @(negedge clk);
        a_in = 1'b0; b_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 inputs ignored when idle", {busy, cell_s1, cell_s0, cell_b, cell_a},
              {1'b0, model(1'b1, 1'b0, 9)});

        // R1: reset mid-run
        @(negedge clk);
        a_in = 1'b1; b_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run", {busy, done, step_idx, cell_s1, cell_s0, cell_b, cell_a}, 10'd0);

        // back-to-back run after reset
        run(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule